// File: doc/BRIEF.md
# External-Clock Serial Result Readout with Optional Sync Marker

This block shifts a 16-bit conversion result out of a converter one bit per pulse of a data clock that the receiver supplies. The clock is discontinuous: it runs only while the receiver wants a word, and it may rest either high or low between bursts. The block samples that clock, the active-low chip select, the read/convert control and the active-low busy flag in its own system clock domain. From them it decides when a read window is open, which result word to send, and at which pulse each bit appears.

A read window is open while chip select is low and read/convert is high. The receiver can read during a conversion, while busy is low, and then gets the previous result. It can also wait until busy returns high and get the result just finished. The receiver can arm a one-pulse sync marker by toggling the data clock while chip select is high, or while chip select and read/convert are both low. When armed, the first pulse of the next burst produces the marker. Every data bit then arrives one pulse later than in an unarmed burst.

The sequencer state machine has five states. `ST_IDLE`: the window is closed and both outputs are low. `ST_WAIT`: the window is open but no rising edge has come yet. `ST_SYNC`: the marker slot. `ST_SHIFT`: bits run MSB first. `ST_HOLD`: the pulses after the LSB. Transitions:
- window closes: any state to `ST_IDLE`.
- window opens: `ST_IDLE` to `ST_WAIT`.
- first rising edge: `ST_IDLE` or `ST_WAIT` to `ST_SYNC` if armed, else to `ST_SHIFT`.
- next rising edge: `ST_SYNC` to `ST_SHIFT`.
- rising edge at bit 0: `ST_SHIFT` to `ST_HOLD`.

Top module: `exsync_serializer`

## Requirements
- R1: While chip select is high or read/convert is low, `data_out` and `sync_out` are both low, from the first system clock after the window closes.
- R2: The word is chosen at the first rising data-clock edge of a burst. It is `prev_word` if `busy_n` is low then, and `cur_word` if `busy_n` is high.
- R3: Any data-clock transition, rising or falling, arms the sync marker if it happens while `cs_n` is high, or while `cs_n` and `rc` are both low.
- R4: When armed, `sync_out` is high and `data_out` is low from the 1st rising edge of the burst until its 2nd rising edge.
- R5: When armed, bit 15 (MSB) appears after the 2nd rising edge and bit 0 after the 17th, one bit per rising edge.
- R6: When not armed, bit 15 appears after the 1st rising edge and bit 0 after the 16th, and `sync_out` stays low.
- R7: Rising edges after the LSB keep driving bit 0 until the window closes.
- R8: A rising edge of `cs_n`, or a convert command, clears the arm flag and the bit position, so the next burst starts again from its first slot. A convert command is a falling `rc` while `cs_n` is low.
- R9: Only rising data-clock edges inside the window advance the bit position. This holds with the clock resting high or low between bursts.
- R10: Inside an open window, before the first rising edge, `data_out` and `sync_out` are low.
- R11: After reset both outputs are low and the marker is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Receiver-supplied discontinuous data clock |
| cs_n | input | 1 | Chip select, active low |
| rc | input | 1 | Read/convert control: high = read, low = convert |
| busy_n | input | 1 | Low while a conversion is in progress |
| cur_word | input | WORD_W | Result of the latest finished conversion |
| prev_word | input | WORD_W | Result of the conversion before it |
| data_out | output | 1 | Serial result bit |
| sync_out | output | 1 | One-slot sync marker |

## Verification
Embedded properties check several rules on every cycle:
- both outputs are quiet whenever the window is closed;
- a marker only appears when the arm flag was set;
- the arm flag sets on any qualifying clock transition and clears on a chip-select rise;
- a falling edge or an idle clock never moves the sequencer;
- the held LSB does not change.

Some behaviour only the scenarios can show:
- that the bit order and the one-pulse shift caused by the marker are correct;
- that busy selects the right word;
- that an aborted burst restarts at the MSB;
- that a convert command disarms a marker armed earlier.

These scenarios run the four combinations of read timing and marker use, with both clock rest levels.

// File: rtl/exsync_pkg.sv
package exsync_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SYNC,
        ST_SHIFT,
        ST_HOLD
    } rd_state_e;
endpackage

// File: rtl/dclk_edges.sv
module dclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    output logic rise_o,
    output logic fall_o,
    output logic tog_o
);
    logic dclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dclk_q <= 1'b0;
        else        dclk_q <= dclk_i;
    end

    assign rise_o = dclk_i & ~dclk_q;
    assign fall_o = ~dclk_i & dclk_q;
    assign tog_o  = dclk_i ^ dclk_q;
endmodule

// File: rtl/sync_arm.sv
module sync_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    input  logic cs_n_i,
    input  logic rc_i,
    output logic armed_o
);
    logic cs_q;
    logic rc_q;
    logic set_w;
    logic clr_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
            rc_q <= 1'b1;
        end else begin
            cs_q <= cs_n_i;
            rc_q <= rc_i;
        end
    end

    assign set_w = tog_i & (cs_n_i | ~rc_i);
    assign clr_w = (cs_n_i & ~cs_q) | (~cs_n_i & ~rc_i & rc_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed_o <= 1'b0;
        else if (set_w) armed_o <= 1'b1;
        else if (clr_w) armed_o <= 1'b0;
    end

    // R3: a qualifying transition always leaves the flag set
    a_r3_arm_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_i && (cs_n_i || !rc_i)) |=> armed_o);

    // R8: chip select rising without a transition disarms
    a_r8_cs_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!tog_i && cs_n_i && !$past(cs_n_i)) |=> !armed_o);
endmodule

// File: rtl/bit_sequencer.sv
module bit_sequencer
    import exsync_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_i,
    input  logic              rise_i,
    input  logic              armed_i,
    input  logic              busy_n_i,
    input  logic [WORD_W-1:0] cur_word_i,
    input  logic [WORD_W-1:0] prev_word_i,
    output logic              data_o,
    output logic              sync_o
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

    rd_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [WORD_W-1:0] word_q, word_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        word_d  = word_q;
        if (!win_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WAIT: begin
                    if (rise_i) begin
                        word_d  = busy_n_i ? cur_word_i : prev_word_i;
                        idx_d   = TOP_IDX;
                        state_d = armed_i ? ST_SYNC : ST_SHIFT;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
                ST_SYNC: begin
                    if (rise_i) state_d = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (rise_i) begin
                        if (idx_q == '0) state_d = ST_HOLD;
                        else             idx_d   = idx_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        data_o = 1'b0;
        sync_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                data_o = 1'b0;
                sync_o = 1'b0;
            end
            ST_SYNC:  sync_o = 1'b1;
            ST_SHIFT: data_o = word_q[idx_q];
            ST_HOLD:  data_o = word_q[0];
            default: begin
                data_o = 1'b0;
                sync_o = 1'b0;
            end
        endcase
    end

    // R4: marker only follows an armed flag
    a_r4_sync_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(armed_i));

    // R9: without a rising edge an active sequencer does not move
    a_r9_only_rise_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i && !rise_i && state_q != ST_IDLE) |=> (state_q == $past(state_q)));

    // R7: the held LSB stays put
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && win_i) |=> (data_o == $past(data_o)));
endmodule

// File: rtl/exsync_serializer.sv
module exsync_serializer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dclk,
    input  logic              cs_n,
    input  logic              rc,
    input  logic              busy_n,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] prev_word,
    output logic              data_out,
    output logic              sync_out
);
    logic rise_w;
    logic fall_w;
    logic tog_w;
    logic armed_w;
    logic win_w;

    assign win_w = ~cs_n & rc;

    dclk_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .dclk_i (dclk),
        .rise_o (rise_w),
        .fall_o (fall_w),
        .tog_o  (tog_w)
    );

    sync_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_i   (tog_w),
        .cs_n_i  (cs_n),
        .rc_i    (rc),
        .armed_o (armed_w)
    );

    bit_sequencer #(.WORD_W(WORD_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_i       (win_w),
        .rise_i      (rise_w),
        .armed_i     (armed_w),
        .busy_n_i    (busy_n),
        .cur_word_i  (cur_word),
        .prev_word_i (prev_word),
        .data_o      (data_out),
        .sync_o      (sync_out)
    );

    // R1: closed window silences both outputs on the next cycle
    a_r1_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !win_w |=> (!data_out && !sync_out));

    // R9: a falling edge alone never raises the marker
    a_r9_fall_no_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_w && !sync_out) |=> !sync_out);
endmodule

// File: tb/exsync_serializer_tb.sv
module exsync_serializer_tb;
    localparam int W  = 16;
    localparam int HP = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         rc = 1'b1;
    logic         busy_n = 1'b1;
    logic [W-1:0] cur_word = '0;
    logic [W-1:0] prev_word = '0;
    logic         data_out;
    logic         sync_out;

    int    nchk = 0;
    int    nfail = 0;
    int    cycles = 0;
    logic  idle_lvl = 1'b0;
    bit    exp_d[$];
    bit    exp_s[$];
    string exp_tag[$];

    exsync_serializer #(.WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .cs_n(cs_n), .rc(rc),
        .busy_n(busy_n), .cur_word(cur_word), .prev_word(prev_word),
        .data_out(data_out), .sync_out(sync_out)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic check(string tag, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet(string tag);
        check({tag, " data"}, data_out, 1'b0);
        check({tag, " sync"}, sync_out, 1'b0);
    endtask

    task automatic dpulse();
        dclk = ~idle_lvl; tick(HP);
        dclk = idle_lvl;  tick(HP);
    endtask

    // driver: push expected slot per pulse, then produce the pulse
    task automatic burst(logic [W-1:0] w, bit syn, int n, string tag);
        for (int k = 1; k <= n; k++) begin
            int idx;
            if (syn && k == 1) begin
                exp_d.push_back(1'b0); exp_s.push_back(1'b1);
            end else begin
                idx = (W - 1) - (k - (syn ? 2 : 1));
                if (idx < 0) idx = 0;
                exp_d.push_back(w[idx]); exp_s.push_back(1'b0);
            end
            exp_tag.push_back($sformatf("%s pulse %0d", tag, k));
            dpulse();
        end
    endtask

    // monitor: rising edge of the data clock settles one system clock later
    always @(posedge dclk) begin
        if (exp_d.size() > 0) begin
            bit    d;
            bit    s;
            string t;
            d = exp_d.pop_front(); s = exp_s.pop_front(); t = exp_tag.pop_front();
            @(negedge clk);
            check({t, " data"}, data_out, d);
            check({t, " sync"}, sync_out, s);
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        quiet("R11 reset");

        for (int pol = 0; pol < 2; pol++) begin
            idle_lvl  = logic'(pol);
            dclk      = idle_lvl;
            prev_word = (pol == 0) ? 16'hA5C3 : 16'h3C81;
            cur_word  = (pol == 0) ? 16'h5E17 : 16'hC06B;
            cs_n = 1'b0; rc = 1'b1; tick(4);

            // during conversion, no marker (R6, R2 prev)
            rc = 1'b0; tick(2);
            busy_n = 1'b0; rc = 1'b1; tick(2);
            quiet("R10 open no edge");
            burst(prev_word, 0, 17, "R6 R2 R7 during");
            rc = 1'b0; tick(2);
            quiet("R1 rc low");
            busy_n = 1'b1; tick(2);

            // during conversion, marker armed with rc low (R3, R4, R5)
            dpulse();
            quiet("R1 pulses rc low");
            busy_n = 1'b0; rc = 1'b1; tick(2);
            burst(prev_word, 1, 18, "R4 R5 R7 during");
            rc = 1'b0; tick(2);
            busy_n = 1'b1; tick(2);

            // after conversion, no marker (R2 cur)
            rc = 1'b0; tick(1); busy_n = 1'b0; rc = 1'b1; tick(4);
            cur_word = ~cur_word; busy_n = 1'b1; tick(2);
            burst(cur_word, 0, 17, "R2 R6 after");

            // after conversion, marker armed with cs high (R3)
            rc = 1'b0; tick(1); busy_n = 1'b0; rc = 1'b1; tick(2);
            cur_word = cur_word ^ 16'h0FF0; busy_n = 1'b1; tick(2);
            cs_n = 1'b1; tick(2);
            quiet("R1 cs high");
            dpulse();
            quiet("R1 cs high pulse");
            cs_n = 1'b0; tick(2);
            burst(cur_word, 1, 18, "R3 R5 after");

            // abort by chip select restarts at MSB (R8)
            rc = 1'b0; tick(2); rc = 1'b1; tick(2);
            burst(cur_word, 0, 5, "R8 pre-abort");
            cs_n = 1'b1; tick(2);
            quiet("R8 R1 abort");
            cs_n = 1'b0; tick(2);
            burst(cur_word, 0, 3, "R8 restart");

            // arm, then convert command disarms (R8)
            rc = 1'b0; tick(1);
            dpulse();
            rc = 1'b1; tick(2);
            rc = 1'b0; tick(2);
            rc = 1'b1; tick(2);
            burst(cur_word, 0, 2, "R8 convert clears");
            rc = 1'b0; tick(4);
        end

        tick(10);
        check("R9 scoreboard drained", logic'(exp_d.size() == 0), 1'b1);
        summary();
    end
endmodule